// File: doc/BRIEF.md
# Gaussian Noise Sample Generator

This block turns a stream of uniform pseudo-random words into integer noise samples whose distribution follows a bell curve. A 32-bit linear-feedback shift register supplies one uniform 16-bit word per draw. That word is looked up in a 64-entry table of cumulative-probability thresholds. The table must rise monotonically and is loaded by the host before use. The result of a draw is the position in the table of the first threshold that is not smaller than the word. The result is never the threshold value itself.

To tighten the shape toward a true normal curve, one, two or four successive draws can be added together. The sum is centred on zero by subtracting 32 for each draw, and then it leaves the block as one signed sample with a single-cycle strobe. The host fills the table while the block is paused, picks a seed and a summing mode, and raises the enable to let samples flow.

Top module: `gauss_noise_gen`

## Requirements
- R1: The uniform source is a Galois shift register that shifts right with feedback mask 0x80200003. Each draw takes bits [31:16] of the current state as the uniform word, and the register then advances exactly one step.
- R2: A seed-load pulse installs the seed value, or 0x1D2C3B4A when the seed is zero. The same constant is the reset state. The pulse also abandons any draw or partial sum in progress.
- R3: The index of a draw is the lowest i in 0..63 with threshold[i] >= uniform word, or 63 when no entry qualifies. The bench checks that every table it loads is non-decreasing.
- R4: sum_mode 00 sums 1 draw, 01 sums 2 and 10 or 11 sums 4. The sample is the sum of the indices minus 32 per draw, in 9-bit two's complement.
- R5: sample_vld is high for exactly one cycle per completed sum, and sample holds its value between strobes.
- R6: For a single draw, sample_vld rises 6 clock edges after the edge at which the draw starts. With enable held high, draws follow every 7 cycles.
- R7: A draw starts only at an edge where en is high. A draw already running finishes even if en falls.
- R8: Table writes are ignored while en is high.
- R9: After reset, sample_vld is 0 and sample is 0.
- R10: sum_mode is sampled at the first draw of a sum. A change during the sum applies only from the next sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new draws; blocks table writes |
| seed_ld | input | 1 | Load seed_val into the shift register |
| seed_val | input | 32 | Seed value (zero is replaced) |
| tbl_we | input | 1 | Threshold table write strobe |
| tbl_addr | input | 6 | Table write index |
| tbl_data | input | 16 | Threshold value to write |
| sum_mode | input | 2 | Number of draws per sample |
| sample | output | 9 | Signed, centred noise sample |
| sample_vld | output | 1 | One-cycle strobe for a new sample |

## Verification
A draw starts at the edge where en is seen high from idle. Its one-draw result and strobe appear 6 edges later, and the next draw can begin on the following edge, so sums of N draws complete every 7N cycles. The directed latency test drives en at a falling edge and counts falling edges, expecting the strobe low on the first six and high on the seventh. The random phases do not rely on timing at all: at each falling edge the bench compares any strobed sample against the next value from its own draw-by-draw model.

// File: rtl/gng_pkg.sv
package gng_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SRCH = 1'b1
  } srch_state_e;

  // Draws per sample for a summing-mode code (R4).
  function automatic logic [2:0] sum_count(input logic [1:0] mode);
    case (mode)
      2'b00:   sum_count = 3'd1;
      2'b01:   sum_count = 3'd2;
      default: sum_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/gng_lfsr.sv
module gng_lfsr #(
  parameter int          W        = 32,
  parameter logic [W-1:0] MASK     = 32'h8020_0003,
  parameter logic [W-1:0] SEED_DEF = 32'h1D2C_3B4A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED_DEF;
    else if (load) state <= (seed == '0) ? SEED_DEF : seed;
    else if (step) state <= nxt;
  end

  // R2: a zero seed never reaches the register, and the shift keeps it nonzero
  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    state != '0);

endmodule

// File: rtl/gng_cdf_table.sv
module gng_cdf_table #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/gng_search.sv
module gng_search
  import gng_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          en,
  input  logic [DW-1:0] u_in,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic          start,
  output logic          done,
  output logic [AW-1:0] idx
);

  localparam int          BW   = (AW > 1) ? $clog2(AW) : 1;
  localparam logic [AW-1:0] ROOT = AW'((1 << (AW - 1)) - 1);

  srch_state_e   state;
  logic [DW-1:0] u_q;
  logic [AW-1:0] pos;
  logic [BW-1:0] bitn;
  logic [AW-1:0] step_val;
  logic [AW-1:0] npos;
  logic          lt;
  logic          last;

  always_comb begin
    step_val = AW'(1) << bitn;
    lt       = rdata < u_q;
    npos     = lt ? (pos | step_val) : pos;
    last     = (bitn == '0);
    if (state == S_SRCH && !last)
      raddr = npos | ((step_val >> 1) - AW'(1));
    else
      raddr = ROOT;
    start = (state == S_IDLE) && en && !abort;
    done  = (state == S_SRCH) && last && !abort;
    idx   = npos;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= S_IDLE;
      u_q   <= '0;
      pos   <= '0;
      bitn  <= '0;
    end else begin
      case (state)
        S_IDLE: if (en) begin
          u_q   <= u_in;
          pos   <= '0;
          bitn  <= BW'(AW - 1);
          state <= S_SRCH;
        end
        default: begin
          if (last) begin
            state <= S_IDLE;
          end else begin
            pos  <= npos;
            bitn <= bitn - BW'(1);
          end
        end
      endcase
    end
  end

  // R7: an idle search with enable low stays idle
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !en) |=> (state == S_IDLE));

  // R6: a search ends one step after its last bit is reached
  p_done_returns_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (state == S_IDLE));

endmodule

// File: rtl/gng_accum.sv
module gng_accum
  import gng_pkg::*;
#(
  parameter int IW = 6,
  parameter int OW = IW + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic                 done,
  input  logic [IW-1:0]        idx,
  output logic signed [OW-1:0] sample,
  output logic                 valid
);

  localparam int HALF = 1 << (IW - 1);

  logic [2:0]    n_q;
  logic [1:0]    cnt;
  logic [OW-1:0] acc;
  logic [OW-1:0] tot;
  logic [OW-1:0] centre;
  logic          fin;

  always_comb begin
    tot    = acc + OW'(idx);
    centre = OW'(n_q) << (IW - 1);
    fin    = ({1'b0, cnt} + 3'd1) == n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q    <= 3'd1;
      cnt    <= '0;
      acc    <= '0;
      sample <= '0;
      valid  <= 1'b0;
    end else if (abort) begin
      cnt   <= '0;
      acc   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start && cnt == '0) n_q <= sum_count(mode);
      if (done) begin
        if (fin) begin
          sample <= tot - centre;
          valid  <= 1'b1;
          acc    <= '0;
          cnt    <= '0;
        end else begin
          acc <= tot;
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  // R5: the strobe never lasts two cycles
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R10: the partial-sum count stays below the latched draw count
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < n_q));

  // R4: a strobed sample lies inside the centred range for its draw count
  p_range_r4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(sample) >= -(int'(n_q) * HALF) &&
               int'(sample) <= int'(n_q) * (HALF - 1)));

endmodule

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen #(
  parameter int          LFSR_W       = 32,
  parameter logic [31:0] LFSR_MASK    = 32'h8020_0003,
  parameter logic [31:0] SEED_DEFAULT = 32'h1D2C_3B4A,
  parameter int          THR_W        = 16,
  parameter int          IDX_W        = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      seed_ld,
  input  logic [LFSR_W-1:0]         seed_val,
  input  logic                      tbl_we,
  input  logic [IDX_W-1:0]          tbl_addr,
  input  logic [THR_W-1:0]          tbl_data,
  input  logic [1:0]                sum_mode,
  output logic signed [IDX_W+2:0]   sample,
  output logic                      sample_vld
);

  localparam int OUT_W = IDX_W + 3;

  logic [LFSR_W-1:0] lfsr_q;
  logic [THR_W-1:0]  uni;
  logic [THR_W-1:0]  rdata;
  logic [IDX_W-1:0]  raddr;
  logic [IDX_W-1:0]  idx;
  logic              start;
  logic              done;
  logic              wr_ok;

  assign uni   = lfsr_q[LFSR_W-1 -: THR_W];
  assign wr_ok = tbl_we && !en;

  gng_lfsr #(
    .W       (LFSR_W),
    .MASK    (LFSR_W'(LFSR_MASK)),
    .SEED_DEF(LFSR_W'(SEED_DEFAULT))
  ) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .load (seed_ld),
    .seed (seed_val),
    .step (start),
    .state(lfsr_q)
  );

  gng_cdf_table #(
    .AW(IDX_W),
    .DW(THR_W)
  ) u_table (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(tbl_addr),
    .wdata(tbl_data),
    .raddr(raddr),
    .rdata(rdata)
  );

  gng_search #(
    .AW(IDX_W),
    .DW(THR_W)
  ) u_search (
    .clk  (clk),
    .rst  (rst),
    .abort(seed_ld),
    .en   (en),
    .u_in (uni),
    .rdata(rdata),
    .raddr(raddr),
    .start(start),
    .done (done),
    .idx  (idx)
  );

  gng_accum #(
    .IW(IDX_W),
    .OW(OUT_W)
  ) u_accum (
    .clk   (clk),
    .rst   (rst),
    .abort (seed_ld),
    .start (start),
    .mode  (sum_mode),
    .done  (done),
    .idx   (idx),
    .sample(sample),
    .valid (sample_vld)
  );

  // R8: no table write is performed while draws are allowed
  p_no_write_when_en_r8: assert property (@(posedge clk) disable iff (rst)
    en |-> !wr_ok);

endmodule

// File: tb/gauss_noise_gen_tb.sv
module gauss_noise_gen_tb;

  localparam logic [31:0] DEF_SEED = 32'h1D2C_3B4A;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              seed_ld = 1'b0;
  logic [31:0]       seed_val = '0;
  logic              tbl_we = 1'b0;
  logic [5:0]        tbl_addr = '0;
  logic [15:0]       tbl_data = '0;
  logic [1:0]        sum_mode = 2'b00;
  logic signed [8:0] sample;
  logic              sample_vld;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_s;
  logic [15:0] m_tbl [64];

  always #2 clk = ~clk;

  gauss_noise_gen u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seed_ld   (seed_ld),
    .seed_val  (seed_val),
    .tbl_we    (tbl_we),
    .tbl_addr  (tbl_addr),
    .tbl_data  (tbl_data),
    .sum_mode  (sum_mode),
    .sample    (sample),
    .sample_vld(sample_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    lfsr_next = {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic int find_idx(input logic [15:0] u);
    for (int i = 0; i < 64; i++)
      if (m_tbl[i] >= u) return i;
    return 63;
  endfunction

  function automatic int n_of(input logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  task automatic model_sample(input int n, output int r);
    int acc = 0;
    for (int k = 0; k < n; k++) begin
      acc += find_idx(m_s[31:16]);
      m_s = lfsr_next(m_s);
    end
    r = acc - n * 32;
  endtask

  task automatic load_seed(input logic [31:0] v);
    @(negedge clk);
    seed_ld  = 1'b1;
    seed_val = v;
    @(negedge clk);
    seed_ld  = 1'b0;
    m_s = (v == 32'h0) ? DEF_SEED : v;
  endtask

  // Loads a table (en must be low) and checks its order first (R3).
  task automatic write_table(input int kind);
    logic [15:0] t [64];
    bit mono = 1'b1;
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: begin
          real x;
          x = (real'(i) + 1.0 - 32.0) / 8.0;
          t[i] = (i == 63) ? 16'hFFFF :
                 16'($rtoi(65535.0 / (1.0 + $exp(-1.702 * x))));
        end
        1: t[i] = 16'hFFFF;
        default: t[i] = 16'h0000;
      endcase
    end
    for (int i = 1; i < 64; i++)
      if (t[i] < t[i-1]) mono = 1'b0;
    chk(mono, "R3 table order", int'(mono), 1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl_we   = 1'b1;
      tbl_addr = 6'(i);
      tbl_data = t[i];
      m_tbl[i] = t[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic collect(input int k, input bit rnd_en, input string tag);
    int got = 0;
    int cyc = 0;
    int exp_v;
    while (got < k && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (sample_vld) begin
        model_sample(n_of(sum_mode), exp_v);
        chk(int'(sample) == exp_v, tag, int'(sample), exp_v);
        got++;
      end
      en = rnd_en ? (($urandom % 4) != 0) : 1'b1;
    end
    chk(got == k, {tag, " count"}, got, k);
    en = 1'b0;
  endtask

  task automatic drain();
    en = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int exp_v;
    int t1;
    int t2;
    int junk;
    junk = $urandom(777);
    repeat (5) @(negedge clk);
    // R9: reset state
    chk(sample_vld == 1'b0, "R9 reset valid", int'(sample_vld), 0);
    chk(sample == 9'sd0, "R9 reset sample", int'(sample), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sample_vld == 1'b0, "R9 valid after reset", int'(sample_vld), 0);

    write_table(0);

    // R6 / R7: single draw latency, en dropped after the start edge
    sum_mode = 2'b00;
    load_seed(32'h1234_5678);
    en = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) en = 1'b0;
      if (k < 7)
        chk(sample_vld == 1'b0, "R6 early strobe", int'(sample_vld), 0);
      else begin
        chk(sample_vld == 1'b1, "R6 strobe on 6th edge", int'(sample_vld), 1);
        model_sample(1, exp_v);
        chk(int'(sample) == exp_v, "R3 single draw value", int'(sample), exp_v);
      end
    end
    // R5 / R7: one-cycle strobe, held sample, no draw while en is low
    t1 = int'(sample);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sample_vld || int'(sample) != t1)
        chk(1'b0, "R7 idle with en low", int'(sample_vld), 0);
    end
    chk(int'(sample) == t1, "R5 sample held", int'(sample), t1);

    // R6: back-to-back draws every 7 cycles
    load_seed(32'hCAFE_0001);
    en = 1'b1;
    t1 = 0;
    t2 = 0;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (sample_vld) begin
        model_sample(1, exp_v);
        chk(int'(sample) == exp_v, "R1 back-to-back value", int'(sample), exp_v);
        if (t1 == 0) t1 = k; else t2 = k;
      end
    end
    chk(t1 == 7, "R6 first strobe", t1, 7);
    chk(t2 - t1 == 7, "R6 draw period", t2 - t1, 7);
    drain();

    // R2: zero seed replaced by the default constant
    load_seed(32'h0);
    collect(6, 1'b0, "R2 zero seed");
    drain();

    // R1 R3 R4: random seeds, all modes, random enable
    for (int p = 0; p < 8; p++) begin
      sum_mode = 2'(p % 4);
      load_seed($urandom);
      collect(20, 1'b1, "R4 random phase");
      drain();
    end

    // R10: mode change in the middle of a 4-draw sum
    sum_mode = 2'b10;
    load_seed(32'h0BAD_F00D);
    en = 1'b1;
    collect(1, 1'b0, "R10 first sum");
    en = 1'b1;
    repeat (10) @(negedge clk);
    sum_mode = 2'b00;
    t1 = 0;
    while (t1 < 2) begin
      @(negedge clk);
      if (sample_vld) begin
        model_sample(t1 == 0 ? 4 : 1, exp_v);
        chk(int'(sample) == exp_v, "R10 mode latched", int'(sample), exp_v);
        t1++;
      end
    end
    drain();

    // R8: writes ignored while en is high
    write_table(1);
    sum_mode = 2'b00;
    load_seed(32'h5555_AAAA);
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tbl_we   = 1'b1;
      tbl_addr = 6'(i);
      tbl_data = 16'h0000;
    end
    @(negedge clk);
    tbl_we = 1'b0;
    collect(8, 1'b0, "R8 write ignored");
    drain();

    // R3: no threshold qualifies -> index 63
    write_table(2);
    load_seed(32'h7777_1111);
    collect(8, 1'b0, "R3 clamp to top");
    drain();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule